// File: doc/BRIEF.md
# Multi-Sequencer Sample FIFO Unit

This block gathers samples for a converter front end. It holds four sample sequencers, and each one owns a 16-entry FIFO. When a one-cycle pulse arrives on the trigger input, some sequencers respond. A sequencer responds only when its enable bit is set and its 4-bit event field selects the timer source (code 5). Each responding sequencer pushes one sample word into its FIFO and raises its raw interrupt bit. No real conversion takes place. Sample words come from a 32-bit pseudo-random generator, so software sees values that vary but can be predicted.

Software reaches the unit through a simple register port. Writes are registered. Reads are combinational from the address. Each sequencer has a window of four words: an input-select register, a control register, a pop port and a packed status word. There are four interrupt lines, and each one is its sequencer's raw bit ANDed with its mask bit. The unit also keeps priority and averaging registers, which it stores and reads back only. A write to the processor-initiate register is accepted and has no effect.

Top module: `sample_seq_fifo`

## Requirements
- R1: After reset, every FIFO status word reads 0x100 (empty, pointers 0), and the enable, raw, mask and status/clear registers read 0. All irq lines are low.
- R2: Global map: 0x00 enables (bit n = sequencer n), 0x04 raw, 0x08 mask, 0x0C status/clear, 0x14 event select (16 bits, field n at bits 4n+3:4n). On a trig pulse, every sequencer with its enable set and field == 5 pushes one sample and sets raw bit n. Other sequencers keep their status and raw bit.
- R3: The generator starts at 0. For each responding sequencer, in increasing index order, it steps g = g*314159 + 1 (mod 2^32), and that sequencer's sample is 0x200 + g[18:16]. The step happens even when the FIFO is full.
- R4: Sequencer n's window starts at 0x40 + n*0x20. Its status word sits at +0x0C: read pointer in bits 3:0, write pointer in bits 7:4, empty in bit 8, full in bit 12. A push clears empty and advances the write pointer modulo 16. Full is set when the two pointers become equal.
- R5: A push into a full FIFO is discarded, leaving the pointers and the stored data unchanged. The raw bit is still set.
- R6: A read of +0x08 pops the oldest sample, clears full, advances the read pointer and sets empty when it meets the write pointer. A pop from an empty FIFO returns 0 and changes nothing.
- R7: irq[n] is high exactly when raw bit n and mask bit n are both set. Reading 0x0C returns raw AND mask.
- R8: Writing 1s to 0x0C clears those raw bits. If a trigger sets the same bit in the same cycle, the bit stays set.
- R9: A pop and a push to the same FIFO in one cycle both take effect. Each is judged against the state before the edge: the read returns the old head, and a pop on an empty FIFO still lets the push land.
- R10: +0x00 of a window stores the written value masked with 0x33333333. +0x04, 0x20 and 0x30 store full words. A write to 0x28 pushes nothing and changes no status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig | input | 1 | Timer trigger pulse |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (pops at pop offsets) |
| addr | input | 8 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from addr |
| irq | output | 4 | Per-sequencer interrupt, raw AND mask |

## Verification
Two events can land on the same clock edge: a trigger push and a software pop on the same FIFO, and a trigger set and a software clear on the same raw bit. The bench raises trig and a pop strobe together on one FIFO that holds one entry, and again on one that is empty. In each case it compares the returned data with the sample that was expected before the edge, then reads back the status word to check the pointer and flag results. It also pulses trig in the same cycle as a write-1-to-clear of the bit that trigger sets, and expects the raw bit to read 1 afterwards.

// File: rtl/sample_seq_fifo.sv
module sample_seq_fifo #(
  parameter int NSEQ     = 4,
  parameter int PW       = 4,
  parameter int SAMPW    = 10,
  parameter int AW       = 8,
  parameter logic [3:0] TRIG_SEL = 4'd5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trig,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [AW-1:0]   addr,
  input  logic [31:0]     wdata,
  output logic [31:0]     rdata,
  output logic [NSEQ-1:0] irq
);
  localparam int DEPTH = 1 << PW;
  localparam int SW    = $clog2(NSEQ);
  localparam int EVW   = 4 * NSEQ;
  localparam logic [AW-1:0] A_EN   = AW'(8'h00);
  localparam logic [AW-1:0] A_RAW  = AW'(8'h04);
  localparam logic [AW-1:0] A_MSK  = AW'(8'h08);
  localparam logic [AW-1:0] A_CLR  = AW'(8'h0C);
  localparam logic [AW-1:0] A_EV   = AW'(8'h14);
  localparam logic [AW-1:0] A_PRI  = AW'(8'h20);
  localparam logic [AW-1:0] A_AVG  = AW'(8'h30);
  localparam logic [AW-1:0] A_WIN  = AW'(8'h40);

  logic [NSEQ-1:0]         enab, mask, raw;
  logic [EVW-1:0]          evsel;
  logic [31:0]             prio, avg, gen;
  logic [NSEQ-1:0][31:0]   insel, ctl;
  logic [NSEQ-1:0][PW-1:0] rp, wp;
  logic [NSEQ-1:0]         emp, ful, push_req, pop_req;
  logic [SAMPW-1:0]        mem [NSEQ][DEPTH];
  logic [31:0]             gchain [NSEQ+1];

  logic          in_win;
  logic [SW-1:0] sidx;
  logic [4:0]    sub;
  logic          gwr;

  assign in_win = (addr >= A_WIN) && ({1'b0, addr} < (AW+1)'(64 + NSEQ * 32));
  assign sidx   = SW'((addr - A_WIN) >> 5);
  assign sub    = addr[4:0];
  assign gwr    = wr_en && !in_win;
  assign irq    = raw & mask;

  always_comb begin
    gchain[0] = gen;
    for (int n = 0; n < NSEQ; n++)
      gchain[n+1] = push_req[n] ? gchain[n] * 32'd314159 + 32'd1 : gchain[n];
  end

  for (genvar n = 0; n < NSEQ; n++) begin : g_seq
    logic do_push, do_pop;
    assign push_req[n] = trig && enab[n] && (evsel[4*n +: 4] == TRIG_SEL);
    assign pop_req[n]  = rd_en && in_win && (sidx == SW'(n)) && (sub == 5'h08);
    assign do_push = push_req[n] && !ful[n];
    assign do_pop  = pop_req[n] && !emp[n];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rp[n] <= '0; wp[n] <= '0; emp[n] <= 1'b1; ful[n] <= 1'b0;
        insel[n] <= '0; ctl[n] <= '0;
      end else begin
        rp[n] <= rp[n] + PW'(do_pop);
        wp[n] <= wp[n] + PW'(do_push);
        if (do_push && !do_pop) begin
          emp[n] <= 1'b0;
          ful[n] <= (wp[n] + PW'(1)) == rp[n];
        end else if (do_pop && !do_push) begin
          ful[n] <= 1'b0;
          emp[n] <= (rp[n] + PW'(1)) == wp[n];
        end
        if (wr_en && in_win && sidx == SW'(n)) begin
          if (sub == 5'h00) insel[n] <= wdata & 32'h3333_3333;
          if (sub == 5'h04) ctl[n]   <= wdata;
        end
      end
    end

    always_ff @(posedge clk)
      if (do_push) mem[n][wp[n]] <= SAMPW'(32'h200 + {29'd0, gchain[n+1][18:16]});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enab <= '0; mask <= '0; raw <= '0; evsel <= '0;
      prio <= '0; avg <= '0; gen <= '0;
    end else begin
      gen <= gchain[NSEQ];
      raw <= (raw & ~((gwr && addr == A_CLR) ? wdata[NSEQ-1:0] : '0)) | push_req;
      if (gwr) begin
        case (addr)
          A_EN:    enab  <= wdata[NSEQ-1:0];
          A_MSK:   mask  <= wdata[NSEQ-1:0];
          A_EV:    evsel <= wdata[EVW-1:0];
          A_PRI:   prio  <= wdata;
          A_AVG:   avg   <= wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (in_win) begin
      case (sub)
        5'h00: rdata = insel[sidx];
        5'h04: rdata = ctl[sidx];
        5'h08: rdata = emp[sidx] ? '0 : 32'(mem[sidx][rp[sidx]]);
        5'h0C: rdata = (32'(ful[sidx]) << 12) | (32'(emp[sidx]) << 8)
                     | (32'(wp[sidx]) << 4) | 32'(rp[sidx]);
        default: rdata = '0;
      endcase
    end else begin
      case (addr)
        A_EN:    rdata = 32'(enab);
        A_RAW:   rdata = 32'(raw);
        A_MSK:   rdata = 32'(mask);
        A_CLR:   rdata = 32'(raw & mask);
        A_EV:    rdata = 32'(evsel);
        A_PRI:   rdata = prio;
        A_AVG:   rdata = avg;
        default: rdata = '0;
      endcase
    end
  end
endmodule

module sample_seq_fifo_chk #(
  parameter int NSEQ = 4,
  parameter int PW   = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NSEQ-1:0]         emp,
  input logic [NSEQ-1:0]         ful,
  input logic [NSEQ-1:0]         push_req,
  input logic [NSEQ-1:0]         pop_req,
  input logic [NSEQ-1:0]         raw,
  input logic [NSEQ-1:0]         mask,
  input logic [NSEQ-1:0]         irq,
  input logic [NSEQ-1:0][PW-1:0] rp,
  input logic [NSEQ-1:0][PW-1:0] wp
);
  for (genvar g = 0; g < NSEQ; g++) begin : g_chk
    // R4
    flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(emp[g] && ful[g]));
    // R6
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      emp[g] && pop_req[g] && !push_req[g] |=> emp[g] && $stable(rp[g]));
    // R5
    full_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ful[g] && push_req[g] && !pop_req[g] |=> ful[g] && $stable(wp[g]));
    // R2
    trig_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push_req[g] |=> raw[g]);
    // R7
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq[g] |-> mask[g] && raw[g]);
  end
endmodule

bind sample_seq_fifo sample_seq_fifo_chk #(.NSEQ(NSEQ), .PW(PW)) chk_i (
  .clk(clk), .rst_n(rst_n), .emp(emp), .ful(ful), .push_req(push_req),
  .pop_req(pop_req), .raw(raw), .mask(mask), .irq(irq), .rp(rp), .wp(wp)
);

// File: tb/sample_seq_fifo_tb.sv
module sample_seq_fifo_tb_top;
  logic clk = 0, rst_n = 0, trig = 0, wr_en = 0, rd_en = 0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  irq;
  int nchk = 0, nerr = 0;
  logic [31:0] g = 0;

  sample_seq_fifo dut_i (.clk(clk), .rst_n(rst_n), .trig(trig), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  always #2 clk = ~clk;

  // {write, addr, data}; for reads data is the expected value
  localparam logic [40:0] VEC [14] = '{
    {1'b0, 8'h4C, 32'h100},        // R1
    {1'b0, 8'h6C, 32'h100},        // R1
    {1'b0, 8'h8C, 32'h100},        // R1
    {1'b0, 8'hAC, 32'h100},        // R1
    {1'b0, 8'h00, 32'h0},          // R1
    {1'b0, 8'h0C, 32'h0},          // R1
    {1'b1, 8'h40, 32'hFFFF_FFFF},
    {1'b0, 8'h40, 32'h3333_3333},  // R10
    {1'b1, 8'h64, 32'h1234_5678},
    {1'b0, 8'h64, 32'h1234_5678},  // R10
    {1'b1, 8'h20, 32'h0000_3210},
    {1'b0, 8'h20, 32'h0000_3210},  // R10
    {1'b1, 8'h14, 32'hABCD_1234},
    {1'b0, 8'h14, 32'h0000_1234}   // R2
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
    @(negedge clk); addr = a; rd_en = 1; #1;
    check(req, rdata, exp);
    @(negedge clk); rd_en = 0;
  endtask

  task automatic pulse();
    @(negedge clk); trig = 1;
    @(negedge clk); trig = 0;
  endtask

  function automatic logic [31:0] adv();
    g = g * 32'd314159 + 32'd1;
    return 32'h200 + {29'd0, g[18:16]};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [31:0] s0, s2, sn, sm;
    logic [31:0] exp_q [16];
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    #1 check("R1 irq", 32'(irq), 32'h0);

    for (int i = 0; i < 14; i++) begin
      if (VEC[i][40]) wr(VEC[i][39:32], VEC[i][31:0]);
      else rd(VEC[i][39:32], VEC[i][31:0], $sformatf("table[%0d]", i));
    end

    // R10: initiate write does nothing; R2: no field selects timer
    wr(8'h00, 32'hF);
    wr(8'h28, 32'hF);
    rd(8'h4C, 32'h100, "R10 initiate status");
    rd(8'h04, 32'h0, "R10 initiate raw");
    pulse();
    rd(8'h6C, 32'h100, "R2 unselected status");
    rd(8'h04, 32'h0, "R2 unselected raw");

    // R2, R3: sequencers 0 and 2 select the timer
    wr(8'h14, 32'h0505);
    pulse();
    s0 = adv(); s2 = adv();
    rd(8'h4C, 32'h010, "R4 seq0 status after push");
    rd(8'h6C, 32'h100, "R2 seq1 untouched");
    rd(8'h8C, 32'h010, "R2 seq2 status");
    rd(8'hAC, 32'h100, "R2 seq3 untouched");
    rd(8'h04, 32'h5, "R2 raw bits");
    #1 check("R7 irq masked off", 32'(irq), 32'h0);
    wr(8'h08, 32'h1);
    #1 check("R7 irq seq0", 32'(irq), 32'h1);
    rd(8'h0C, 32'h1, "R7 masked status");

    // R6, R3
    rd(8'h48, s0, "R3 seq0 sample");
    rd(8'h4C, 32'h111, "R6 seq0 empty after pop");
    rd(8'h48, 32'h0, "R6 pop empty data");
    rd(8'h4C, 32'h111, "R6 pop empty status");
    rd(8'h88, s2, "R3 seq2 sample");
    rd(8'h8C, 32'h111, "R6 seq2 status");

    // R8
    wr(8'h0C, 32'h1);
    rd(8'h04, 32'h4, "R8 clear bit0");
    #1 check("R8 irq after clear", 32'(irq), 32'h0);
    wr(8'h0C, 32'h4);

    // R5: fill seq0
    wr(8'h14, 32'h0005);
    for (int i = 0; i < 16; i++) begin
      pulse();
      exp_q[i] = adv();
    end
    rd(8'h4C, 32'h1011, "R5 full status");
    wr(8'h0C, 32'h1);
    pulse();
    void'(adv());
    rd(8'h4C, 32'h1011, "R5 overflow status");
    rd(8'h04, 32'h1, "R5 overflow raw");
    rd(8'h48, exp_q[0], "R5 first after overflow");
    rd(8'h4C, 32'h012, "R6 full cleared");
    for (int i = 1; i < 16; i++) rd(8'h48, exp_q[i], $sformatf("R5 drain %0d", i));
    rd(8'h4C, 32'h111, "R6 drained");

    // R9: same-cycle push and pop
    pulse();
    sn = adv();
    rd(8'h4C, 32'h021, "R9 one entry");
    @(negedge clk); addr = 8'h48; rd_en = 1; trig = 1; #1;
    check("R9 old head returned", rdata, sn);
    @(negedge clk); rd_en = 0; trig = 0;
    sn = adv();
    rd(8'h4C, 32'h032, "R9 both applied");
    rd(8'h48, sn, "R9 new sample");
    rd(8'h4C, 32'h133, "R9 empty again");
    @(negedge clk); addr = 8'h48; rd_en = 1; trig = 1; #1;
    check("R9 empty pop data", rdata, 32'h0);
    @(negedge clk); rd_en = 0; trig = 0;
    sm = adv();
    rd(8'h4C, 32'h043, "R9 push on empty pop");
    rd(8'h48, sm, "R9 pushed sample");

    // R8: set wins over clear
    wr(8'h0C, 32'hF);
    rd(8'h04, 32'h0, "R8 all cleared");
    @(negedge clk); addr = 8'h0C; wdata = 32'h1; wr_en = 1; trig = 1;
    @(negedge clk); wr_en = 0; trig = 0;
    void'(adv());
    rd(8'h04, 32'h1, "R8 set beats clear");
    #1 check("R7 irq follows raw", 32'(irq), 32'h1);

    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule